// File: doc/BRIEF.md
# Trace Line-Fill Controller

After a trace cache miss this block builds the missing trace line. The request carries the start address of the trace. The fetch path then hands over basic blocks, one per cycle. Each block comes with its instructions, a two-bit control-type code per instruction, the address of its first instruction, the target of its closing branch and that branch's direction. The block packs these instructions back to back into a line of `SLOTS` instruction slots. It records the direction of each branch and counts the branches as they arrive.

A line is finished when it holds `SLOTS` instructions or `MAXBR` branches, whichever happens first. At that point the block works out the two successor addresses and presents the whole line to the trace store for exactly one cycle. A control transfer whose target cannot be predicted throws the line away. A pipeline flush does the same.

Only one line is built at a time. The block ignores further miss requests until it is idle again.

Top module: `trace_line_fill`

## Requirements
- R1: After reset the block is idle, with `busy` and `wrEn` low. In the idle state, a `missValid` pulse sets `busy` on the next cycle and starts a fill. `missAddr` is kept as the line tag.
- R2: The following inputs change nothing: `missValid` while busy (including the write cycle), and `blkValid` while idle. The tag of the line in progress stays the same, and no write comes from them.
- R3: Each accepted block is placed starting at the first empty slot. Slot k of the block lands in slot `fill+k`. Slots that are never filled read as zero in the written line.
- R4: A block that would run past `SLOTS` slots is cut off after the last slot. Instructions past that point are dropped, including a closing branch. The line then completes with `wrCount == SLOTS`, and `wrFallThru` is the address of the first dropped instruction.
- R5: The line completes as soon as its branch count reaches `MAXBR`, even if slots are still empty.
- R6: `wrFlags` bit i holds the direction (1 = taken) of the i-th branch of the line, with bit 0 the first branch. Only the first `MAXBR-1` branches get a flag bit. `wrBrCount` gives the number of branches. `wrEndsBr` is 1 when the last accepted instruction is a branch.
- R7: A block ends in a branch only if the code of its last instruction is a branch code. The codes are 2'b00 (ordinary instruction), 2'b01 (conditional branch, direction from `blkTaken`), 2'b10 (call or unconditional branch, always counted as taken) and 2'b11 (return, indirect jump or trap).
- R8: The successor addresses of a line depend on how it ends, with addresses counted in instructions. If it ends in a branch, `wrFallThru` is that branch's address plus one and `wrTarget` is `blkTarget`. Otherwise both equal the address that follows the last accepted instruction.
- R9: A code 2'b11 in any accepted slot aborts the fill: there is no write and the block goes back to idle. A code 2'b11 only in slots dropped by truncation does not abort.
- R10: `flush` returns the block to idle on the next cycle. The fill in progress is discarded and never written.
- R11: `wrEn` is high for exactly one cycle, the cycle after the completing block is accepted. The line fields are valid in that cycle, and the block is idle on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard any fill in progress |
| missValid | input | 1 | Trace cache miss request |
| missAddr | input | ADDR_W | Start address of the missed trace |
| blkValid | input | 1 | Basic block present this cycle |
| blkInstr | input | SLOTS*INSTR_W | Block instructions, slot 0 in the low bits |
| blkKind | input | 2*SLOTS | Control-type code per instruction slot |
| blkCount | input | $clog2(SLOTS+1) | Instructions in the block, 1 to SLOTS |
| blkAddr | input | ADDR_W | Address of the block's first instruction |
| blkTarget | input | ADDR_W | Target of the block's closing branch |
| blkTaken | input | 1 | Direction of a conditional closing branch |
| busy | output | 1 | A fill or write is in progress |
| wrEn | output | 1 | Write strobe for the finished line |
| wrTag | output | ADDR_W | Line start address |
| wrInstr | output | SLOTS*INSTR_W | Assembled instructions |
| wrCount | output | $clog2(SLOTS+1) | Instructions in the line |
| wrBrCount | output | $clog2(MAXBR+1) | Branches in the line |
| wrEndsBr | output | 1 | Last instruction is a branch |
| wrFlags | output | MAXBR-1 | Branch directions, first branch in bit 0 |
| wrTarget | output | ADDR_W | Next address if the final branch is taken |
| wrFallThru | output | ADDR_W | Next address if the final branch is not taken |

## Verification
The bench aims at the point where a block overruns the line. A merge that used the block count instead of the remaining room would write past the last slot, count the dropped branch, or point the fall-through at the block's end instead of the first dropped instruction.

It sends return-type codes both inside and outside the accepted slots. A design that checked all slots would abort a line that is valid. It also checks the always-taken code, where a design that ignored it would record a not-taken flag.

Further tests send miss requests during a fill and during the write cycle, a flush in the middle of a fill, and blocks while idle. A design that got any of these wrong would retag the line, write twice, or write a line that had been discarded.

// File: rtl/tfill_pkg.sv
package tfill_pkg;

  typedef enum logic [1:0] {
    KIND_PLAIN  = 2'b00,
    KIND_COND   = 2'b01,
    KIND_ALWAYS = 2'b10,
    KIND_ESCAPE = 2'b11
  } instrKind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_FILL  = 2'b01,
    ST_WRITE = 2'b10
  } fillState_e;

  typedef struct packed {
    logic start;
    logic accept;
    logic finish;
    logic clear;
  } fillCtrl_t;

endpackage

// File: rtl/tfill_datapath.sv
module tfill_datapath
  import tfill_pkg::*;
#(
  parameter int SLOTS   = 16,
  parameter int MAXBR   = 3,
  parameter int INSTR_W = 32,
  parameter int ADDR_W  = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  fillCtrl_t                  ctrl,
  input  logic [ADDR_W-1:0]          missAddr,
  input  logic [SLOTS*INSTR_W-1:0]   blkInstr,
  input  logic [2*SLOTS-1:0]         blkKind,
  input  logic [$clog2(SLOTS+1)-1:0] blkCount,
  input  logic [ADDR_W-1:0]          blkAddr,
  input  logic [ADDR_W-1:0]          blkTarget,
  input  logic                       blkTaken,
  output logic                       blkAbort,
  output logic                       blkCompletes,
  output logic [SLOTS*INSTR_W-1:0]   lineInstr,
  output logic [$clog2(SLOTS+1)-1:0] lineCount,
  output logic [ADDR_W-1:0]          lineTag,
  output logic [$clog2(MAXBR+1)-1:0] lineBrCount,
  output logic                       lineEndsBr,
  output logic [MAXBR-2:0]           lineFlags,
  output logic [ADDR_W-1:0]          lineTarget,
  output logic [ADDR_W-1:0]          lineFallThru
);

  localparam int CNT_W  = $clog2(SLOTS + 1);
  localparam int BR_W   = $clog2(MAXBR + 1);
  localparam int IDX_W  = $clog2(SLOTS);
  localparam int FLAG_W = MAXBR - 1;

  logic [CNT_W-1:0]  fillCnt;
  logic [BR_W-1:0]   brCnt;
  logic [ADDR_W-1:0] tagQ;
  logic [FLAG_W-1:0] flagsQ;
  logic              endsBrQ;
  logic [ADDR_W-1:0] targetQ;
  logic [ADDR_W-1:0] fallQ;

  logic [CNT_W-1:0]  room;
  logic [CNT_W-1:0]  take;
  logic [CNT_W-1:0]  sumCnt;
  logic [BR_W-1:0]   newBr;
  logic              truncated;
  logic              endBranch;
  logic              dirTaken;
  instrKind_e        lastKind;
  logic [ADDR_W-1:0] nextAddr;

  // How much of the incoming block fits behind what is already held.
  always_comb begin
    room      = CNT_W'(SLOTS) - fillCnt;
    truncated = blkCount > room;
    take      = truncated ? room : blkCount;
    sumCnt    = fillCnt + take;
    nextAddr  = blkAddr + ADDR_W'(take);
  end

  // Type of the block's last instruction selects how it closes.
  always_comb begin
    lastKind = KIND_PLAIN;
    for (int s = 0; s < SLOTS; s++) begin
      if (CNT_W'(s + 1) == blkCount) lastKind = instrKind_e'(blkKind[s*2 +: 2]);
    end
  end

  // Any unpredictable transfer among the kept slots spoils the line.
  always_comb begin
    blkAbort = 1'b0;
    for (int s = 0; s < SLOTS; s++) begin
      if ((CNT_W'(s) < take) && (instrKind_e'(blkKind[s*2 +: 2]) == KIND_ESCAPE))
        blkAbort = 1'b1;
    end
  end

  always_comb begin
    endBranch    = !truncated && ((lastKind == KIND_COND) || (lastKind == KIND_ALWAYS));
    dirTaken     = (lastKind == KIND_ALWAYS) | blkTaken;
    newBr        = brCnt + BR_W'(endBranch);
    blkCompletes = (sumCnt == CNT_W'(SLOTS)) || (newBr == BR_W'(MAXBR));
  end

  // Merge network: each slot picks its instruction from the block by offset.
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [INSTR_W-1:0] slotQ;
    logic [IDX_W-1:0]   relIdx;
    logic               slotHit;

    always_comb begin
      relIdx  = IDX_W'(CNT_W'(s) - fillCnt);
      slotHit = (CNT_W'(s) >= fillCnt) && (CNT_W'(s) < sumCnt);
    end

    always_ff @(posedge clk) begin
      if (!rstN || ctrl.clear || ctrl.start) begin
        slotQ <= '0;
      end else if (ctrl.accept && slotHit) begin
        slotQ <= blkInstr[int'(relIdx)*INSTR_W +: INSTR_W];
      end
    end

    assign lineInstr[s*INSTR_W +: INSTR_W] = slotQ;
  end

  // Counters, tag and branch mask state.
  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clear) begin
      fillCnt <= '0;
      brCnt   <= '0;
      tagQ    <= '0;
      flagsQ  <= '0;
    end else if (ctrl.start) begin
      fillCnt <= '0;
      brCnt   <= '0;
      tagQ    <= missAddr;
      flagsQ  <= '0;
    end else if (ctrl.accept) begin
      fillCnt <= sumCnt;
      brCnt   <= newBr;
      if (endBranch) begin
        for (int f = 0; f < FLAG_W; f++) begin
          if (brCnt == BR_W'(f)) flagsQ[f] <= dirTaken;
        end
      end
    end
  end

  // Successor addresses are settled only by the completing block.
  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clear || ctrl.start) begin
      endsBrQ <= 1'b0;
      targetQ <= '0;
      fallQ   <= '0;
    end else if (ctrl.finish) begin
      endsBrQ <= endBranch;
      fallQ   <= nextAddr;
      targetQ <= endBranch ? blkTarget : nextAddr;
    end
  end

  assign lineCount    = fillCnt;
  assign lineTag      = tagQ;
  assign lineBrCount  = brCnt;
  assign lineEndsBr   = endsBrQ;
  assign lineFlags    = flagsQ;
  assign lineTarget   = targetQ;
  assign lineFallThru = fallQ;

  // R4
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= CNT_W'(SLOTS));

  // R5
  branch_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    brCnt <= BR_W'(MAXBR));

  // R3
  append_grows_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.accept |=> fillCnt > $past(fillCnt));

  // R8
  plain_end_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.finish && !endBranch) |=> (targetQ == fallQ));

endmodule

// File: rtl/tfill_control.sv
module tfill_control
  import tfill_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      flush,
  input  logic      missValid,
  input  logic      blkValid,
  input  logic      blkAbort,
  input  logic      blkCompletes,
  output fillCtrl_t ctrl,
  output logic      busy,
  output logic      wrEn
);

  fillState_e stateQ;
  fillState_e stateNext;

  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (missValid) stateNext = ST_FILL;
      ST_FILL:  if (blkValid) begin
                  if (blkAbort)          stateNext = ST_IDLE;
                  else if (blkCompletes) stateNext = ST_WRITE;
                end
      ST_WRITE: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
    if (flush) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNext;
  end

  always_comb begin
    ctrl.start  = (stateQ == ST_IDLE) && missValid && !flush;
    ctrl.accept = (stateQ == ST_FILL) && blkValid && !blkAbort && !flush;
    ctrl.finish = ctrl.accept && blkCompletes;
    ctrl.clear  = flush || (stateQ == ST_WRITE) ||
                  ((stateQ == ST_FILL) && blkValid && blkAbort);
  end

  assign busy = (stateQ != ST_IDLE);
  assign wrEn = (stateQ == ST_WRITE);

  // R11
  write_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);

  // R11
  write_after_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> ($past(stateQ) == ST_FILL));

  // R10
  flush_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !busy);

  // R2
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == ST_FILL) && !blkValid && !flush) |=> (stateQ == ST_FILL));

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == ST_FILL) && blkValid && blkAbort) |=> (!busy && !wrEn));

endmodule

// File: rtl/trace_line_fill.sv
module trace_line_fill
  import tfill_pkg::*;
#(
  parameter int SLOTS   = 16,
  parameter int MAXBR   = 3,
  parameter int INSTR_W = 32,
  parameter int ADDR_W  = 32,
  localparam int CNT_W  = $clog2(SLOTS + 1),
  localparam int BR_W   = $clog2(MAXBR + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     flush,
  input  logic                     missValid,
  input  logic [ADDR_W-1:0]        missAddr,
  input  logic                     blkValid,
  input  logic [SLOTS*INSTR_W-1:0] blkInstr,
  input  logic [2*SLOTS-1:0]       blkKind,
  input  logic [CNT_W-1:0]         blkCount,
  input  logic [ADDR_W-1:0]        blkAddr,
  input  logic [ADDR_W-1:0]        blkTarget,
  input  logic                     blkTaken,
  output logic                     busy,
  output logic                     wrEn,
  output logic [ADDR_W-1:0]        wrTag,
  output logic [SLOTS*INSTR_W-1:0] wrInstr,
  output logic [CNT_W-1:0]         wrCount,
  output logic [BR_W-1:0]          wrBrCount,
  output logic                     wrEndsBr,
  output logic [MAXBR-2:0]         wrFlags,
  output logic [ADDR_W-1:0]        wrTarget,
  output logic [ADDR_W-1:0]        wrFallThru
);

  fillCtrl_t ctrl;
  logic      blkAbort;
  logic      blkCompletes;

  tfill_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .flush        (flush),
    .missValid    (missValid),
    .blkValid     (blkValid),
    .blkAbort     (blkAbort),
    .blkCompletes (blkCompletes),
    .ctrl         (ctrl),
    .busy         (busy),
    .wrEn         (wrEn)
  );

  tfill_datapath #(
    .SLOTS   (SLOTS),
    .MAXBR   (MAXBR),
    .INSTR_W (INSTR_W),
    .ADDR_W  (ADDR_W)
  ) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .missAddr     (missAddr),
    .blkInstr     (blkInstr),
    .blkKind      (blkKind),
    .blkCount     (blkCount),
    .blkAddr      (blkAddr),
    .blkTarget    (blkTarget),
    .blkTaken     (blkTaken),
    .blkAbort     (blkAbort),
    .blkCompletes (blkCompletes),
    .lineInstr    (wrInstr),
    .lineCount    (wrCount),
    .lineTag      (wrTag),
    .lineBrCount  (wrBrCount),
    .lineEndsBr   (wrEndsBr),
    .lineFlags    (wrFlags),
    .lineTarget   (wrTarget),
    .lineFallThru (wrFallThru)
  );

endmodule

// File: tb/tb_trace_line_fill.sv
module tb_trace_line_fill;

  localparam int SLOTS = 16;
  localparam int MAXBR = 3;
  localparam int IW    = 32;
  localparam int AW    = 32;
  localparam int CW    = $clog2(SLOTS + 1);
  localparam int BW    = $clog2(MAXBR + 1);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              flush = 1'b0;
  logic              missValid = 1'b0;
  logic [AW-1:0]     missAddr = '0;
  logic              blkValid = 1'b0;
  logic [SLOTS*IW-1:0] blkInstr = '0;
  logic [2*SLOTS-1:0]  blkKind = '0;
  logic [CW-1:0]     blkCount = '0;
  logic [AW-1:0]     blkAddr = '0;
  logic [AW-1:0]     blkTarget = '0;
  logic              blkTaken = 1'b0;
  logic              busy, wrEn, wrEndsBr;
  logic [AW-1:0]     wrTag, wrTarget, wrFallThru;
  logic [SLOTS*IW-1:0] wrInstr;
  logic [CW-1:0]     wrCount;
  logic [BW-1:0]     wrBrCount;
  logic [MAXBR-2:0]  wrFlags;

  trace_line_fill dut (
    .clk(clk), .rstN(rstN), .flush(flush), .missValid(missValid), .missAddr(missAddr),
    .blkValid(blkValid), .blkInstr(blkInstr), .blkKind(blkKind), .blkCount(blkCount),
    .blkAddr(blkAddr), .blkTarget(blkTarget), .blkTaken(blkTaken), .busy(busy), .wrEn(wrEn),
    .wrTag(wrTag), .wrInstr(wrInstr), .wrCount(wrCount), .wrBrCount(wrBrCount),
    .wrEndsBr(wrEndsBr), .wrFlags(wrFlags), .wrTarget(wrTarget), .wrFallThru(wrFallThru)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int writesSeen = 0;
  bit finished = 0;
  logic [MAXBR-2:0] lastFlags;
  logic [AW-1:0]    lastTag, lastTarget, lastFall;
  logic [CW-1:0]    lastCount;
  logic [BW-1:0]    lastBr;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: 0 idle, 1 filling, 2 writing.
  int           mState = 0;
  logic [AW-1:0] mTag = '0;
  logic [IW-1:0] mQ[$];
  int           mBr = 0;
  logic [1:0]   mFlags = '0;
  bit           mEnds = 0;
  logic [AW-1:0] mTarget = '0;
  logic [AW-1:0] mFall = '0;

  always @(posedge clk) begin
    int room, take, cnt;
    bit ab, eb, dir;
    logic [1:0] lk;
    if (!rstN) begin
      mState = 0; mQ.delete(); mBr = 0; mFlags = '0;
    end else if (flush) begin
      mState = 0; mQ.delete(); mBr = 0; mFlags = '0;
    end else begin
      case (mState)
        0: if (missValid) begin
             mState = 1; mTag = missAddr; mQ.delete(); mBr = 0; mFlags = '0;
           end
        1: if (blkValid) begin
             cnt  = int'(blkCount);
             room = SLOTS - mQ.size();
             take = (cnt < room) ? cnt : room;
             ab = 0;
             for (int i = 0; i < take; i++) if (blkKind[i*2 +: 2] == 2'b11) ab = 1;
             if (ab) begin
               mState = 0; mQ.delete(); mBr = 0; mFlags = '0;
             end else begin
               for (int i = 0; i < take; i++) mQ.push_back(blkInstr[i*IW +: IW]);
               lk  = blkKind[(cnt-1)*2 +: 2];
               eb  = (cnt <= room) && (lk == 2'b01 || lk == 2'b10);
               dir = (lk == 2'b10) || blkTaken;
               if (eb) begin
                 if (mBr < MAXBR-1) mFlags[mBr] = dir;
                 mBr++;
               end
               if (mQ.size() == SLOTS || mBr == MAXBR) begin
                 mState = 2; mEnds = eb; mFall = blkAddr + AW'(take);
                 mTarget = eb ? blkTarget : mFall;
               end
             end
           end
        default: begin
          mState = 0; mQ.delete(); mBr = 0; mFlags = '0;
        end
      endcase
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R1", "busy", busy, mState != 0);
      chk("R11", "wrEn", wrEn, mState == 2);
      if (mState == 2) begin
        chk("R1", "tag", wrTag, mTag);
        chk("R4", "count", wrCount, mQ.size());
        for (int s = 0; s < SLOTS; s++)
          chk("R3", "slot", wrInstr[s*IW +: IW], (s < mQ.size()) ? mQ[s] : '0);
        chk("R6", "brCount", wrBrCount, mBr);
        chk("R6", "endsBr", wrEndsBr, mEnds);
        chk("R6", "flags", wrFlags, mFlags);
        chk("R8", "target", wrTarget, mTarget);
        chk("R8", "fallThru", wrFallThru, mFall);
      end
      if (wrEn) begin
        writesSeen++;
        lastFlags = wrFlags; lastTag = wrTag; lastTarget = wrTarget;
        lastFall = wrFallThru; lastCount = wrCount; lastBr = wrBrCount;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL R11 watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic gap(int n);
    repeat (n) step();
  endtask

  task automatic doMiss(logic [AW-1:0] a);
    missValid = 1'b1; missAddr = a;
    step();
    missValid = 1'b0;
  endtask

  task automatic doFlush();
    flush = 1'b1;
    step();
    flush = 1'b0;
  endtask

  task automatic doBlock(logic [AW-1:0] a, int cnt, logic [1:0] lk, bit taken,
                         logic [AW-1:0] tgt, int escAt);
    for (int i = 0; i < SLOTS; i++) begin
      blkInstr[i*IW +: IW] = 32'hA000_0000 + a + AW'(i);
      blkKind[i*2 +: 2]    = 2'b00;
    end
    blkKind[(cnt-1)*2 +: 2] = lk;
    if (escAt >= 0) blkKind[escAt*2 +: 2] = 2'b11;
    blkCount = CW'(cnt); blkAddr = a; blkTarget = tgt; blkTaken = taken;
    blkValid = 1'b1;
    step();
    blkValid = 1'b0;
  endtask

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    step();
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "wrEn after reset", wrEn, 0);

    // Branch limit, with the always-taken code on the second branch.
    base = writesSeen;
    doMiss(32'h100);
    doBlock(32'h100, 4, 2'b01, 1, 32'h200, -1);
    doBlock(32'h200, 3, 2'b10, 0, 32'h300, -1);
    doBlock(32'h300, 5, 2'b01, 0, 32'h400, -1);
    gap(3);
    chk("R5", "writes on branch limit", writesSeen - base, 1);
    chk("R7", "always-taken flag", lastFlags, 2'b11);
    chk("R6", "count on branch limit", lastCount, 12);
    chk("R8", "target on branch end", lastTarget, 32'h400);
    chk("R8", "fall-through on branch end", lastFall, 32'h305);

    // Instruction limit with a truncated block; its branch is dropped.
    base = writesSeen;
    doMiss(32'h1000);
    doBlock(32'h1000, 10, 2'b01, 0, 32'h1800, -1);
    doBlock(32'h2000, 10, 2'b01, 1, 32'h2800, -1);
    gap(3);
    chk("R4", "count on truncation", lastCount, 16);
    chk("R4", "fall-through first dropped", lastFall, 32'h2006);
    chk("R8", "target equals fall-through", lastTarget, 32'h2006);
    chk("R6", "dropped branch not counted", lastBr, 1);

    // Exact fill ending in a branch.
    doMiss(32'h4000);
    doBlock(32'h4000, 16, 2'b01, 1, 32'h5000, -1);
    gap(3);
    chk("R8", "exact fill target", lastTarget, 32'h5000);
    chk("R8", "exact fill fall-through", lastFall, 32'h4010);

    // Abort inside the accepted slots.
    base = writesSeen;
    doMiss(32'h6000);
    doBlock(32'h6000, 3, 2'b01, 1, 32'h6100, -1);
    doBlock(32'h6100, 5, 2'b01, 1, 32'h6200, 2);
    gap(3);
    chk("R9", "no write after abort", writesSeen - base, 0);
    chk("R9", "idle after abort", busy, 0);

    // Escape code only in a dropped slot does not abort.
    base = writesSeen;
    doMiss(32'h6800);
    doBlock(32'h6800, 12, 2'b00, 0, 32'h0, -1);
    doBlock(32'h6900, 8, 2'b00, 0, 32'h0, 6);
    gap(3);
    chk("R9", "escape in dropped slot writes", writesSeen - base, 1);

    // Misses while busy and blocks while idle are ignored.
    base = writesSeen;
    doBlock(32'h8000, 4, 2'b01, 1, 32'h8100, -1);
    chk("R2", "block while idle", busy, 0);
    doMiss(32'h700);
    doMiss(32'h900);
    doBlock(32'h700, 16, 2'b00, 0, 32'h0, -1);
    doMiss(32'hB00);
    gap(3);
    chk("R2", "tag kept", lastTag, 32'h700);
    chk("R2", "single write", writesSeen - base, 1);
    chk("R2", "miss in write cycle dropped", busy, 0);

    // Flush in mid-fill, then a fresh fill.
    base = writesSeen;
    doMiss(32'hC00);
    doBlock(32'hC00, 5, 2'b01, 1, 32'hD00, -1);
    doFlush();
    gap(3);
    chk("R10", "no write after flush", writesSeen - base, 0);
    doMiss(32'hE00);
    doBlock(32'hE00, 2, 2'b01, 0, 32'hF00, -1);
    doBlock(32'hE02, 2, 2'b01, 1, 32'hF10, -1);
    doBlock(32'hF10, 2, 2'b10, 0, 32'hF20, -1);
    gap(3);
    chk("R10", "fill after flush writes", writesSeen - base, 1);
    chk("R10", "fresh tag", lastTag, 32'hE00);
    chk("R6", "mixed flags", lastFlags, 2'b10);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule